// File: doc/BRIEF.md
# Configurable UART with flow control

This block is a serial transmitter and receiver pair for an asynchronous, start/stop framed line. The character format is chosen at run time through plain configuration pins: five, seven or eight data bits, no parity or even or odd parity, and one or two stop bits. A programmable divider of the system clock sets a 16x oversampling tick. One bit lasts sixteen of those ticks.

Bytes to send enter through a valid/ready stream and leave on `txd`. The transmitter raises `tx_ready` only while it is idle and the far end signals readiness on `cts`. A byte is taken on a cycle where `tx_valid` and `tx_ready` are both high. After that, `tx_ready` stays low until the whole character, stop bits included, has been sent.

Received characters are placed in a single-entry holding register. That register drives a valid/ready output stream together with a parity error flag and a framing error flag. While the holding register is full, the output stays stable, and `rts` tells the far end to stop sending.

Top module: `uart_fc_top`

## Requirements
- R1: After reset `txd` is high, `rts` is high, `rx_valid` is low, and `tx_ready` equals `cts`.
- R2: A character starts with one low start bit, followed by the data bits least significant first. The number of data bits is set by `cfg_len`: 0 gives 5, 1 gives 7, and 2 or 3 give 8.
- R3: `cfg_par` selects parity: 0 or 3 means none, 1 means even, 2 means odd. When parity is on, one parity bit follows the last data bit. Even parity makes the count of ones over the data and parity bits even; odd parity makes it odd.
- R4: The character ends with high stop bits: one when `cfg_stop2` is 0, two when it is 1. `tx_ready` stays low until the last stop bit has ended.
- R5: Each bit after the start bit lasts exactly 16*(`cfg_div`+1) clock cycles.
- R6: `tx_ready` is high only while `cts` is high, and nothing is sent while `cts` is low. A character already started is finished even if `cts` falls during it.
- R7: Between accepting a byte and finishing its character, `tx_ready` is low and `txd` carries the byte that was accepted.
- R8: The receiver delivers each correctly framed character on `rx_data`, with the bits above the configured length set to zero.
- R9: `rx_par_err` is set with the character when the received parity bit does not match the configured parity mode.
- R10: `rx_frm_err` is set with the character when any of its stop bits is sampled low.
- R11: A low pulse on `rxd` shorter than half a bit is ignored and produces no character.
- R12: While `rx_valid` is high and `rx_ready` is low, `rx_valid`, `rx_data` and both flags hold steady and `rts` is low. A character that completes while the holding register is full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | 16 | Oversampling tick period minus one, in clocks |
| cfg_len | input | 2 | Data length select (0:5, 1:7, 2/3:8) |
| cfg_par | input | 2 | Parity select (0/3 none, 1 even, 2 odd) |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Transmitter takes the byte this cycle |
| txd | output | 1 | Serial output, idles high |
| cts | input | 1 | Far end can accept data |
| rxd | input | 1 | Serial input, idles high |
| rts | output | 1 | This receiver can accept data |
| rx_data | output | 8 | Received character |
| rx_par_err | output | 1 | Parity mismatch on `rx_data` |
| rx_frm_err | output | 1 | Stop bit sampled low on `rx_data` |
| rx_valid | output | 1 | Holding register full |
| rx_ready | input | 1 | Consumer takes the held character |

## Verification
The bench covers each data length with each parity mode and both stop counts. A design that miscounted the data length or took parity from the wrong bits would shift or corrupt the decoded word. The bench withholds `cts`, and also drops it in the middle of a frame. A block that ignored `cts` would start a frame early, and one that checked it at every bit would cut a frame short. The bench sends a runt low pulse, a bad parity bit and a low stop bit, and a wrong design would respectively report a phantom character or miss the error flag. It also sends a second character into a full holding register. A design without the single-entry hold would overwrite the unread character or leave `rts` high.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  parameter int unsigned MAX_BITS = 8;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF3 = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_e;

  function automatic logic [3:0] len_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd5;
      2'd1:    return 4'd7;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic par_on(input logic [1:0] m);
    return (m == PAR_EVEN) || (m == PAR_ODD);
  endfunction

  function automatic logic par_bit(input logic [MAX_BITS-1:0] d,
                                   input logic [3:0] n,
                                   input logic [1:0] m);
    logic [MAX_BITS-1:0] mask;
    mask = {MAX_BITS{1'b1}} >> (4'(MAX_BITS) - n);
    return (^(d & mask)) ^ (m == PAR_ODD);
  endfunction
endpackage

// File: rtl/uart_fc_tick.sv
module uart_fc_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
  import uart_fc_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                cts,
  input  logic [1:0]          cfg_len,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_stop2,
  input  logic [MAX_BITS-1:0] in_data,
  input  logic                in_valid,
  output logic                in_ready,
  output logic                txd
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] SUB_LAST = CNT_W'(OVS - 1);

  phase_e              phase;
  logic [MAX_BITS-1:0] sh;
  logic [3:0]          nbits, idx;
  logic [1:0]          pmode;
  logic                stop2, pbit, line_q;
  logic [CNT_W-1:0]    sub;

  assign in_ready = (phase == PH_IDLE) && cts;
  assign txd      = line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      sh     <= '0;
      nbits  <= 4'd8;
      idx    <= '0;
      pmode  <= PAR_NONE;
      stop2  <= 1'b0;
      pbit   <= 1'b0;
      line_q <= 1'b1;
      sub    <= '0;
    end else if (phase == PH_IDLE) begin
      if (in_valid && in_ready) begin
        sh     <= in_data;
        nbits  <= len_bits(cfg_len);
        pmode  <= cfg_par;
        stop2  <= cfg_stop2;
        pbit   <= par_bit(in_data, len_bits(cfg_len), cfg_par);
        sub    <= '0;
        line_q <= 1'b0;
        phase  <= PH_START;
      end
    end else if (tick) begin
      if (sub != SUB_LAST) begin
        sub <= sub + 1'b1;
      end else begin
        sub <= '0;
        case (phase)
          PH_START: begin
            phase  <= PH_DATA;
            idx    <= '0;
            line_q <= sh[0];
            sh     <= sh >> 1;
          end
          PH_DATA: begin
            if (idx == nbits - 4'd1) begin
              idx <= '0;
              if (par_on(pmode)) begin
                phase  <= PH_PAR;
                line_q <= pbit;
              end else begin
                phase  <= PH_STOP;
                line_q <= 1'b1;
              end
            end else begin
              idx    <= idx + 4'd1;
              line_q <= sh[0];
              sh     <= sh >> 1;
            end
          end
          PH_PAR: begin
            phase  <= PH_STOP;
            line_q <= 1'b1;
          end
          default: begin
            if (stop2 && idx == 4'd0) idx <= 4'd1;
            else                      phase <= PH_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
  import uart_fc_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rxd,
  input  logic [1:0]          cfg_len,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_stop2,
  input  logic                rd,
  output logic [MAX_BITS-1:0] out_data,
  output logic                out_perr,
  output logic                out_ferr,
  output logic                out_valid
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] SUB_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] SUB_MID  = CNT_W'(OVS / 2 - 1);

  logic                s1, s2;
  phase_e              phase;
  logic [CNT_W-1:0]    sub;
  logic [3:0]          nbits, idx;
  logic [1:0]          pmode;
  logic                stop2, perr_acc, ferr_acc, full;
  logic [MAX_BITS-1:0] acc;
  logic                sample, frame_done;

  assign sample     = tick && (sub == SUB_LAST);
  assign frame_done = (phase == PH_STOP) && sample && (!stop2 || idx == 4'd1);
  assign out_valid  = full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      sub      <= '0;
      nbits    <= 4'd8;
      idx      <= '0;
      pmode    <= PAR_NONE;
      stop2    <= 1'b0;
      acc      <= '0;
      perr_acc <= 1'b0;
      ferr_acc <= 1'b0;
    end else if (tick) begin
      case (phase)
        PH_IDLE: begin
          if (!s2) begin
            phase <= PH_START;
            sub   <= '0;
          end
        end
        PH_START: begin
          if (s2) begin
            phase <= PH_IDLE;
          end else if (sub == SUB_MID) begin
            phase    <= PH_DATA;
            sub      <= '0;
            idx      <= '0;
            acc      <= '0;
            perr_acc <= 1'b0;
            ferr_acc <= 1'b0;
            nbits    <= len_bits(cfg_len);
            pmode    <= cfg_par;
            stop2    <= cfg_stop2;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        default: begin
          if (!sample) begin
            sub <= sub + 1'b1;
          end else begin
            sub <= '0;
            case (phase)
              PH_DATA: begin
                acc[idx[2:0]] <= s2;
                if (idx == nbits - 4'd1) begin
                  idx   <= '0;
                  phase <= par_on(pmode) ? PH_PAR : PH_STOP;
                end else begin
                  idx <= idx + 4'd1;
                end
              end
              PH_PAR: begin
                perr_acc <= s2 ^ par_bit(acc, nbits, pmode);
                phase    <= PH_STOP;
              end
              default: begin
                if (frame_done) begin
                  phase <= PH_IDLE;
                end else begin
                  ferr_acc <= ferr_acc | ~s2;
                  idx      <= 4'd1;
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full     <= 1'b0;
      out_data <= '0;
      out_perr <= 1'b0;
      out_ferr <= 1'b0;
    end else if (frame_done && (!full || rd)) begin
      full     <= 1'b1;
      out_data <= acc;
      out_perr <= perr_acc;
      out_ferr <= ferr_acc | ~s2;
    end else if (rd) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_fc_top.sv
module uart_fc_top
  import uart_fc_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_len,
  input  logic [1:0]       cfg_par,
  input  logic             cfg_stop2,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  input  logic             cts,
  input  logic             rxd,
  output logic             rts,
  output logic [7:0]       rx_data,
  output logic             rx_par_err,
  output logic             rx_frm_err,
  output logic             rx_valid,
  input  logic             rx_ready
);
  logic tick;

  uart_fc_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
  );

  uart_fc_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cts(cts),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
    .in_data(tx_data), .in_valid(tx_valid), .in_ready(tx_ready), .txd(txd)
  );

  uart_fc_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
    .rd(rx_ready), .out_data(rx_data), .out_perr(rx_par_err),
    .out_ferr(rx_frm_err), .out_valid(rx_valid)
  );

  assign rts = !rx_valid;
endmodule

// File: rtl/uart_fc_sva.sv
module uart_fc_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       cts,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       rts,
  input logic [7:0] rx_data,
  input logic       rx_par_err,
  input logic       rx_frm_err,
  input logic       rx_valid,
  input logic       rx_ready
);
  p_ready_needs_cts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> cts);

  p_idle_line_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !txd);

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);

  p_hold_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data)
                              && $stable(rx_par_err) && $stable(rx_frm_err));

  p_rts_low_when_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !rts);
endmodule

bind uart_fc_top uart_fc_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cts(cts), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .txd(txd), .rts(rts), .rx_data(rx_data),
  .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
  .rx_valid(rx_valid), .rx_ready(rx_ready)
);

// File: tb/tb_uart_fc_top.sv
module tb_uart_fc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_div = 16'd1;
  logic [1:0]  cfg_len = 2'd2, cfg_par = 2'd0;
  logic        cfg_stop2 = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_valid = 1'b0, cts = 1'b1, rxd = 1'b1, rx_ready = 1'b0;
  logic        tx_ready, txd, rts, rx_par_err, rx_frm_err, rx_valid;
  logic [7:0]  rx_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_fc_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_par(cfg_par), .cfg_stop2(cfg_stop2), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .cts(cts),
    .rxd(rxd), .rts(rts), .rx_data(rx_data), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] l);
    return (l == 2'd0) ? 5 : (l == 2'd1) ? 7 : 8;
  endfunction

  function automatic logic [7:0] mask_of(input logic [1:0] l);
    return 8'((1 << nb(l)) - 1);
  endfunction

  function automatic logic exp_par(input logic [7:0] d, input logic [1:0] l,
                                   input logic [1:0] m);
    return (^(d & mask_of(l))) ^ (m == 2'd2);
  endfunction

  function automatic int bclk();
    return 16 * (int'(cfg_div) + 1);
  endfunction

  task automatic tx_frame(input logic [7:0] d, input logic [1:0] l,
                          input logic [1:0] p, input logic s2,
                          input bit drop_cts);
    logic [7:0] got;
    logic       pon;
    pon = (p == 2'd1) || (p == 2'd2);
    @(negedge clk);
    cfg_len = l; cfg_par = p; cfg_stop2 = s2;
    tx_data = d; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0; tx_data = ~d;
    repeat (bclk() / 2 - 1) @(negedge clk);
    chk(txd == 1'b0, "R2", "start bit", int'(txd), 0);
    if (drop_cts) cts = 1'b0;
    got = 8'h00;
    for (int i = 0; i < nb(l); i++) begin
      repeat (bclk()) @(negedge clk);
      got[i] = txd;
    end
    chk(got == (d & mask_of(l)), drop_cts ? "R6" : "R2", "tx data",
        int'(got), int'(d & mask_of(l)));
    if (pon) begin
      repeat (bclk()) @(negedge clk);
      chk(txd == exp_par(d, l, p), "R3", "tx parity", int'(txd),
          int'(exp_par(d, l, p)));
    end
    for (int s = 0; s < (s2 ? 2 : 1); s++) begin
      repeat (bclk()) @(negedge clk);
      chk(txd == 1'b1, "R4", "stop bit high", int'(txd), 1);
      chk(tx_ready == 1'b0, "R7", "busy in stop", int'(tx_ready), 0);
    end
    repeat (bclk() / 2 + int'(cfg_div) + 4) @(negedge clk);
    chk(tx_ready == cts, "R4", "ready after stop", int'(tx_ready), int'(cts));
  endtask

  task automatic rx_bit(input logic v);
    rxd = v;
    repeat (bclk()) @(negedge clk);
  endtask

  task automatic rx_send(input logic [7:0] d, input logic [1:0] l,
                         input logic [1:0] p, input logic s2,
                         input bit bad_par, input bit bad_stop);
    @(negedge clk);
    cfg_len = l; cfg_par = p; cfg_stop2 = s2;
    rx_bit(1'b0);
    for (int i = 0; i < nb(l); i++) rx_bit(d[i]);
    if (p == 2'd1 || p == 2'd2) rx_bit(exp_par(d, l, p) ^ bad_par);
    if (bad_stop) begin
      rxd = 1'b0;
      repeat (bclk() / 2 + 2 * (int'(cfg_div) + 1)) @(negedge clk);
      rxd = 1'b1;
      repeat (bclk() / 2 - 2 * (int'(cfg_div) + 1)) @(negedge clk);
    end else begin
      rx_bit(1'b1);
    end
    if (s2) rx_bit(1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic rx_read();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_expect(input logic [7:0] d, input logic [1:0] l,
                           input bit pe, input bit fe);
    chk(rx_valid == 1'b1, "R8", "rx valid", int'(rx_valid), 1);
    chk(rx_data == (d & mask_of(l)), "R8", "rx data", int'(rx_data),
        int'(d & mask_of(l)));
    chk(rx_par_err == pe, "R9", "parity flag", int'(rx_par_err), int'(pe));
    chk(rx_frm_err == fe, "R10", "framing flag", int'(rx_frm_err), int'(fe));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int low_run, bad;
    logic [7:0] d;
    logic [1:0] l, p;
    logic s2;
    bit pe, fe;
    void'($urandom(32'd7321));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1", "txd idle", int'(txd), 1);
    chk(rts == 1'b1, "R1", "rts idle", int'(rts), 1);
    chk(rx_valid == 1'b0, "R1", "rx_valid idle", int'(rx_valid), 0);
    chk(tx_ready == 1'b1, "R1", "tx_ready with cts", int'(tx_ready), 1);

    // directed formats
    tx_frame(8'hA5, 2'd2, 2'd0, 1'b0, 1'b0);
    tx_frame(8'h1B, 2'd0, 2'd1, 1'b1, 1'b0);
    tx_frame(8'h6C, 2'd1, 2'd2, 1'b0, 1'b0);

    // R6 cts gating
    @(negedge clk);
    cts = 1'b0; tx_data = 8'h3C; tx_valid = 1'b1;
    bad = 0;
    repeat (3 * bclk()) begin
      @(negedge clk);
      if (txd !== 1'b1 || tx_ready !== 1'b0) bad++;
    end
    chk(bad == 0, "R6", "no send while cts low", bad, 0);
    tx_valid = 1'b0;
    cts = 1'b1;
    tx_frame(8'h96, 2'd2, 2'd1, 1'b0, 1'b1);
    chk(tx_ready == 1'b0, "R6", "ready held low by cts", int'(tx_ready), 0);
    cts = 1'b1;

    // R5 bit timing
    cfg_div = 16'd3;
    @(negedge clk);
    cfg_len = 2'd2; cfg_par = 2'd0; cfg_stop2 = 1'b0;
    tx_data = 8'h01; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    while (txd == 1'b0) @(negedge clk);
    while (txd == 1'b1) @(negedge clk);
    low_run = 0;
    while (txd == 1'b0) begin
      low_run++;
      @(negedge clk);
    end
    chk(low_run == 7 * bclk(), "R5", "7-bit low run", low_run, 7 * bclk());
    repeat (2 * bclk()) @(negedge clk);
    cfg_div = 16'd1;
    repeat (40) @(negedge clk);

    // receive directed
    rx_send(8'hC3, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0);
    rx_expect(8'hC3, 2'd2, 1'b0, 1'b0);
    rx_read();
    chk(rx_valid == 1'b0 && rts == 1'b1, "R12", "released after read",
        int'(rx_valid), 0);
    rx_send(8'hFF, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0);
    rx_expect(8'hFF, 2'd0, 1'b0, 1'b0);
    rx_read();
    rx_send(8'h55, 2'd1, 2'd2, 1'b0, 1'b1, 1'b0);
    rx_expect(8'h55, 2'd1, 1'b1, 1'b0);
    rx_read();
    rx_send(8'h81, 2'd2, 2'd0, 1'b1, 1'b0, 1'b1);
    rx_expect(8'h81, 2'd2, 1'b0, 1'b1);
    rx_read();

    // R11 glitch
    rxd = 1'b0;
    repeat (3 * (int'(cfg_div) + 1)) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bclk()) @(negedge clk);
    chk(rx_valid == 1'b0, "R11", "runt pulse ignored", int'(rx_valid), 0);

    // R12 full holding register
    rx_send(8'h2A, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0);
    chk(rts == 1'b0, "R12", "rts low while full", int'(rts), 0);
    rx_send(8'hD4, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0);
    chk(rx_data == 8'h2A, "R12", "unread kept", int'(rx_data), 8'h2A);
    rx_read();
    chk(rx_valid == 1'b0, "R12", "second dropped", int'(rx_valid), 0);

    // random
    for (int k = 0; k < 12; k++) begin
      d = 8'($urandom); l = 2'($urandom); p = 2'($urandom); s2 = 1'($urandom);
      tx_frame(d, l, p, s2, 1'b0);
    end
    for (int k = 0; k < 12; k++) begin
      d = 8'($urandom); l = 2'($urandom); p = 2'($urandom); s2 = 1'($urandom);
      pe = ((p == 2'd1) || (p == 2'd2)) && ($urandom % 3 == 0);
      fe = ($urandom % 4 == 0);
      rx_send(d, l, p, s2, pe, fe);
      rx_expect(d, l, pe, fe);
      rx_read();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule